// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block is the datapath core of a small accumulator machine. From the accumulator value, a second operand (which may come from a register, from memory or from the instruction stream), the present carry and a three-bit operation code, it forms an eight-bit result and five status bits: sign, zero, half-carry, parity and carry. It also states which of the five status bits the operation is allowed to write. Add, add-with-carry, subtract, subtract-with-borrow, operand increment, operand decrement, accumulator complement and rotate-left-circular share one nibble-split adder.

The top level is a thin registered wrapper that holds the five-bit flag register. It feeds the stored carry back as the carry input, so chained add-with-carry and subtract-with-borrow sequences behave the way a program sees them. When an operation is strobed, the wrapper captures the result and the write mask, and it updates only the flag bits that the mask allows. Fetching the operands and writing the accumulator back are left to the surrounding machine.

Top module: `alu8_flagreg`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `res_out` is 00h, `res_upd` is 00000b, `res_vld` is 0 and all five flag outputs are 0.
- R2: Code 0 (add) yields acc+opnd and code 1 (add-with-carry) yields acc+opnd+CY, where CY is the stored carry flag. Carry is set to the bit-8 carry-out. Example: 4Ch+25h with CY=1 gives 72h, half-carry 1, carry 0.
- R3: Code 2 (subtract) yields acc−opnd and code 3 (subtract-with-borrow) yields acc−opnd−CY. Both add the inverted operand and set carry to the inverse of the carry-out, so carry=1 means a borrow. Examples: 15h−27h gives EEh with carry 1; 3Ah−15h with CY=1 gives 24h with carry 0.
- R4: Half-carry is the carry out of bit 3 of the adder. For subtraction it is the low-nibble carry of acc + ~opnd + (1−borrow-in), taken without inversion. Example: 8Ah+28h gives half-carry 1, and 27h+15h gives 0.
- R5: Sign equals result bit 7. Zero is 1 exactly when the result is 00h. Example: 29h−28h with CY=1 gives 00h with zero 1.
- R6: Parity is 1 when the result holds an even number of one bits. Examples: 3Ch gives 1 and 45h gives 0.
- R7: Code 4 yields opnd+1 and code 5 yields opnd−1, both modulo 256. They update sign, zero, half-carry and parity and leave carry unchanged. Examples: FFh+1 gives 00h and FFh−1 gives FEh.
- R8: Code 6 yields the bitwise complement of acc and leaves all five flags unchanged.
- R9: Code 7 yields acc rotated left by one, with bit 7 moved into bit 0, and sets carry to the old acc bit 7. The other four flags are unchanged.
- R10: `res_upd` reports the flag write mask with the bit order {sign, zero, half-carry, parity, carry} from bit 4 down to bit 0. The mask is 11111b for codes 0 to 3, 11110b for codes 4 and 5, 00000b for code 6 and 00001b for code 7.
- R11: An operation is captured on the rising edge where `op_valid` is 1, and `res_vld` is 1 in the following cycle. On an edge where `op_valid` is 0, `res_vld` goes to 0, and `res_out`, `res_upd` and the flags keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe: capture an operation on this edge |
| op_code | input | 3 | Operation code, 0 to 7 as listed in R2, R3 and R7 to R9 |
| acc_val | input | 8 | Accumulator operand |
| opnd_val | input | 8 | Second operand (register, memory or immediate) |
| res_out | output | 8 | Registered result |
| res_upd | output | 5 | Registered flag write mask {S,Z,AC,P,CY} |
| res_vld | output | 1 | Result captured on the previous edge |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Half-carry flag |
| flag_p | output | 1 | Parity flag |
| flag_cy | output | 1 | Carry / borrow flag |

## Verification
The assertions assume that `op_code`, `acc_val` and `opnd_val` are settled at each rising edge where `op_valid` is sampled. They also assume that every three-bit code names an operation, so no encoding is left unchecked. The stimulus changes every input only on the falling edge and reads outputs on the next falling edge. Before each carry-sensitive case it sets up a known carry with an earlier add or subtract, so that add-with-carry, subtract-with-borrow and the carry-preserving increment and decrement are always tried against a carry value the bench has predicted.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_ADC = 3'd1,
        ALU_SUB = 3'd2,
        ALU_SBB = 3'd3,
        ALU_INC = 3'd4,
        ALU_DEC = 3'd5,
        ALU_CMA = 3'd6,
        ALU_RLC = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flag_set_t;

    localparam flag_set_t UPD_ALL   = 5'b11111;
    localparam flag_set_t UPD_NO_CY = 5'b11110;
    localparam flag_set_t UPD_CY    = 5'b00001;
    localparam flag_set_t UPD_NONE  = 5'b00000;

endpackage

// File: rtl/alu8_adder.sv
// Adder split at the nibble boundary so the half carry is a real wire.
module alu8_adder #(
    parameter int DATA_W = 8,
    parameter int LO_W   = 4
) (
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              half_c,
    output logic              full_c
);
    localparam int HI_W = DATA_W - LO_W;

    logic [LO_W:0] lo_sum;
    logic [HI_W:0] hi_sum;

    always_comb begin
        lo_sum  = {1'b0, x_in[LO_W-1:0]} + {1'b0, y_in[LO_W-1:0]}
                + {{LO_W{1'b0}}, c_in};
        hi_sum  = {1'b0, x_in[DATA_W-1:LO_W]} + {1'b0, y_in[DATA_W-1:LO_W]}
                + {{HI_W{1'b0}}, lo_sum[LO_W]};
        sum_out = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
        half_c  = lo_sum[LO_W];
        full_c  = hi_sum[HI_W];
    end
endmodule

// File: rtl/alu8_flaggen.sv
// Result-derived status bits: sign, zero, even parity.
module alu8_flaggen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res_in,
    output logic              sign_o,
    output logic              zero_o,
    output logic              par_o
);
    always_comb begin
        sign_o = res_in[DATA_W-1];
        zero_o = (res_in == '0);
        par_o  = ~^res_in;
    end
endmodule

// File: rtl/alu8_core.sv
// Combinational ALU: operand steering, result select, flags and write mask.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LO_W   = 4
) (
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              cy_in,
    input  alu_op_e           op_in,
    output logic [DATA_W-1:0] res_o,
    output flag_set_t         flags_o,
    output flag_set_t         upd_o
);
    logic [DATA_W-1:0] add_x, add_y, add_sum;
    logic              add_c, borrow_mode, half_c, full_c;
    logic              f_sign, f_zero, f_par;

    always_comb begin
        add_x       = acc_in;
        add_y       = opnd_in;
        add_c       = 1'b0;
        borrow_mode = 1'b0;
        upd_o       = UPD_ALL;
        unique case (op_in)
            ALU_ADD: begin
                add_c = 1'b0;
            end
            ALU_ADC: begin
                add_c = cy_in;
            end
            ALU_SUB: begin
                add_y       = ~opnd_in;
                add_c       = 1'b1;
                borrow_mode = 1'b1;
            end
            ALU_SBB: begin
                add_y       = ~opnd_in;
                add_c       = ~cy_in;
                borrow_mode = 1'b1;
            end
            ALU_INC: begin
                add_x = opnd_in;
                add_y = '0;
                add_c = 1'b1;
                upd_o = UPD_NO_CY;
            end
            ALU_DEC: begin
                add_x = opnd_in;
                add_y = '1;
                add_c = 1'b0;
                upd_o = UPD_NO_CY;
            end
            ALU_CMA: begin
                upd_o = UPD_NONE;
            end
            ALU_RLC: begin
                upd_o = UPD_CY;
            end
            default: begin
                upd_o = UPD_NONE;
            end
        endcase
    end

    alu8_adder #(.DATA_W(DATA_W), .LO_W(LO_W)) u_adder (
        .x_in   (add_x),
        .y_in   (add_y),
        .c_in   (add_c),
        .sum_out(add_sum),
        .half_c (half_c),
        .full_c (full_c)
    );

    always_comb begin
        unique case (op_in)
            ALU_CMA: res_o = ~acc_in;
            ALU_RLC: res_o = {acc_in[DATA_W-2:0], acc_in[DATA_W-1]};
            default: res_o = add_sum;
        endcase
    end

    alu8_flaggen #(.DATA_W(DATA_W)) u_flaggen (
        .res_in(res_o),
        .sign_o(f_sign),
        .zero_o(f_zero),
        .par_o (f_par)
    );

    always_comb begin
        flags_o.s  = f_sign;
        flags_o.z  = f_zero;
        flags_o.p  = f_par;
        flags_o.ac = half_c;
        flags_o.cy = (op_in == ALU_RLC) ? acc_in[DATA_W-1] : (full_c ^ borrow_mode);
    end
endmodule

// File: rtl/alu8_flagreg.sv
// Registered wrapper: captures result and mask, holds the flag register.
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [2:0] op_code,
    input  logic [7:0] acc_val,
    input  logic [7:0] opnd_val,
    output logic [7:0] res_out,
    output logic [4:0] res_upd,
    output logic       res_vld,
    output logic       flag_s,
    output logic       flag_z,
    output logic       flag_ac,
    output logic       flag_p,
    output logic       flag_cy
);
    localparam int DATA_W = 8;
    localparam int LO_W   = 4;

    logic [DATA_W-1:0] core_res;
    flag_set_t         core_flags, core_upd, flag_q, upd_q;
    logic [DATA_W-1:0] res_q;
    logic              vld_q;

    alu8_core #(.DATA_W(DATA_W), .LO_W(LO_W)) u_core (
        .acc_in (acc_val),
        .opnd_in(opnd_val),
        .cy_in  (flag_q.cy),
        .op_in  (alu_op_e'(op_code)),
        .res_o  (core_res),
        .flags_o(core_flags),
        .upd_o  (core_upd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            upd_q  <= UPD_NONE;
            vld_q  <= 1'b0;
            flag_q <= '0;
        end else begin
            vld_q <= op_valid;
            if (op_valid) begin
                res_q <= core_res;
                upd_q <= core_upd;
                if (core_upd.s)  flag_q.s  <= core_flags.s;
                if (core_upd.z)  flag_q.z  <= core_flags.z;
                if (core_upd.ac) flag_q.ac <= core_flags.ac;
                if (core_upd.p)  flag_q.p  <= core_flags.p;
                if (core_upd.cy) flag_q.cy <= core_flags.cy;
            end
        end
    end

    always_comb begin
        res_out = res_q;
        res_upd = upd_q;
        res_vld = vld_q;
        flag_s  = flag_q.s;
        flag_z  = flag_q.z;
        flag_ac = flag_q.ac;
        flag_p  = flag_q.p;
        flag_cy = flag_q.cy;
    end

    assert_vld_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_vld);

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_vld && $stable(res_out) && $stable(res_upd)
                       && $stable({flag_s, flag_z, flag_ac, flag_p, flag_cy})));

    assert_incdec_keeps_cy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 3'd4 || op_code == 3'd5)) |=> $stable(flag_cy));

    assert_cma_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd6)
        |=> ($stable({flag_s, flag_z, flag_ac, flag_p, flag_cy}) && res_out == ~$past(acc_val)));

    assert_rlc_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd7)
        |=> (flag_cy == $past(acc_val[7]) && res_out[0] == $past(acc_val[7])
             && $stable({flag_s, flag_z, flag_ac, flag_p})));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_upd[3]) |-> (flag_z == (res_out == 8'h00)));

    assert_sign_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_upd[4]) |-> (flag_s == res_out[7]));

    assert_parity_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_upd[1]) |-> (flag_p == ~^res_out));
endmodule

// File: tb/alu8_flagreg_bench.sv
module alu8_flagreg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] acc_val = 8'h00;
    logic [7:0] opnd_val = 8'h00;
    logic [7:0] res_out;
    logic [4:0] res_upd;
    logic       res_vld;
    logic       flag_s, flag_z, flag_ac, flag_p, flag_cy;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the flag register {S,Z,AC,P,CY}
    logic [4:0] m_flags = 5'b0;
    logic [7:0] m_res   = 8'h00;
    logic [4:0] m_upd   = 5'b0;

    always #10 clk = ~clk;

    alu8_flagreg u_alu8_flagreg (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_val(acc_val), .opnd_val(opnd_val), .res_out(res_out),
        .res_upd(res_upd), .res_vld(res_vld), .flag_s(flag_s), .flag_z(flag_z),
        .flag_ac(flag_ac), .flag_p(flag_p), .flag_cy(flag_cy)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, got, exp);
        end
    endtask

    function automatic logic [4:0] cur_flags();
        return {flag_s, flag_z, flag_ac, flag_p, flag_cy};
    endfunction

    // compute expectation from the requirements, run one op, compare
    task automatic run_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                          input string req);
        int         wide, lo, cin;
        logic [7:0] r;
        logic       ac_n, cy_n;
        logic [4:0] msk;
        ac_n = 1'b0;
        cy_n = m_flags[0];
        case (op)
            3'd0, 3'd1: begin
                cin  = (op == 3'd1) ? int'(m_flags[0]) : 0;
                wide = int'(a) + int'(b) + cin;
                r    = wide[7:0];
                cy_n = wide > 255;
                lo   = int'(a & 8'h0F) + int'(b & 8'h0F) + cin;
                ac_n = lo > 15;
                msk  = 5'b11111;
            end
            3'd2, 3'd3: begin
                cin  = (op == 3'd3) ? int'(m_flags[0]) : 0;
                wide = int'(a) - int'(b) - cin;
                r    = wide[7:0];
                cy_n = wide < 0;
                lo   = int'(a & 8'h0F) + int'((~b) & 8'h0F) + (1 - cin);
                ac_n = lo > 15;
                msk  = 5'b11111;
            end
            3'd4: begin
                r    = b + 8'd1;
                ac_n = (b & 8'h0F) == 8'h0F;
                msk  = 5'b11110;
            end
            3'd5: begin
                r    = b - 8'd1;
                ac_n = (b & 8'h0F) != 8'h00;
                msk  = 5'b11110;
            end
            3'd6: begin
                r   = ~a;
                msk = 5'b00000;
            end
            default: begin
                r    = {a[6:0], a[7]};
                cy_n = a[7];
                msk  = 5'b00001;
            end
        endcase
        begin
            logic [4:0] nf;
            nf = {r[7], (r == 8'h00), ac_n, ~^r, cy_n};
            for (int i = 0; i < 5; i++)
                if (msk[i]) m_flags[i] = nf[i];
        end
        m_res = r;
        m_upd = msk;
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = op;
        acc_val  = a;
        opnd_val = b;
        @(negedge clk);
        op_valid = 1'b0;
        check({req, " result"}, res_out, m_res);
        check({req, " flags"}, {3'b0, cur_flags()}, {3'b0, m_flags});
        check("R10 mask", {3'b0, res_upd}, {3'b0, m_upd});
        check("R11 valid", {7'b0, res_vld}, 8'h01);
    endtask

    task automatic t_reset();
        check("R1 result", res_out, 8'h00);
        check("R1 mask", {3'b0, res_upd}, 8'h00);
        check("R1 valid", {7'b0, res_vld}, 8'h00);
        check("R1 flags", {3'b0, cur_flags()}, 8'h00);
    endtask

    task automatic t_add();
        run_op(3'd0, 8'h15, 8'h27, "R2 R6 add 3C");
        check("R6 parity even", {7'b0, flag_p}, 8'h01);
        run_op(3'd0, 8'h30, 8'h15, "R6 add 45");
        check("R6 parity odd", {7'b0, flag_p}, 8'h00);
        run_op(3'd0, 8'h8A, 8'h28, "R4 R5 add B2");
        check("R4 half carry", {7'b0, flag_ac}, 8'h01);
        check("R5 sign", {7'b0, flag_s}, 8'h01);
        run_op(3'd0, 8'hFF, 8'h01, "R2 R5 add wrap");
        check("R5 zero", {7'b0, flag_z}, 8'h01);
        check("R2 carry out", {7'b0, flag_cy}, 8'h01);
    endtask

    task automatic t_adc();
        run_op(3'd1, 8'h4C, 8'h25, "R2 adc 72");
        check("R2 adc value", res_out, 8'h72);
        check("R4 adc half", {7'b0, flag_ac}, 8'h01);
    endtask

    task automatic t_sub();
        run_op(3'd2, 8'h15, 8'h27, "R3 R4 sub EE");
        check("R3 borrow set", {6'b0, res_out == 8'hEE, flag_cy}, 8'h03);
        run_op(3'd3, 8'h3A, 8'h15, "R3 sbb 24");
        check("R3 sbb value", {6'b0, res_out == 8'h24, flag_cy}, 8'h02);
        run_op(3'd2, 8'h00, 8'h01, "R3 borrow setup");
        run_op(3'd3, 8'h29, 8'h28, "R3 R5 sbb zero");
        check("R5 sbb zero", {7'b0, flag_z}, 8'h01);
    endtask

    task automatic t_incdec();
        run_op(3'd2, 8'h00, 8'h01, "R7 carry setup");
        run_op(3'd4, 8'h55, 8'hFF, "R7 inc FF");
        check("R7 inc keeps cy", {6'b0, res_out == 8'h00, flag_cy}, 8'h03);
        run_op(3'd5, 8'h55, 8'hFF, "R7 dec FF");
        check("R7 dec value", res_out, 8'hFE);
        run_op(3'd0, 8'h01, 8'h01, "R7 clear cy");
        run_op(3'd5, 8'h00, 8'h00, "R7 dec 00 no cy");
        check("R7 dec keeps cy 0", {7'b0, flag_cy}, 8'h00);
    endtask

    task automatic t_cma();
        run_op(3'd2, 8'h00, 8'h01, "R8 flag setup");
        run_op(3'd6, 8'h5A, 8'h00, "R8 cma");
        check("R8 cma value", res_out, 8'hA5);
    endtask

    task automatic t_rlc();
        run_op(3'd7, 8'h85, 8'h00, "R9 rlc 85");
        check("R9 rlc value", {res_out[6:0], flag_cy}, {7'h0B, 1'b1});
        run_op(3'd7, 8'h40, 8'h00, "R9 rlc 40");
        check("R9 rlc clear cy", {res_out[6:0], flag_cy}, {7'h00, 1'b0});
    endtask

    task automatic t_idle();
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 3'd0;
        acc_val  = 8'hFF;
        opnd_val = 8'hFF;
        @(negedge clk);
        check("R11 idle valid", {7'b0, res_vld}, 8'h00);
        check("R11 idle result", res_out, m_res);
        check("R11 idle flags", {3'b0, cur_flags()}, {3'b0, m_flags});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_adc();
        t_sub();
        t_incdec();
        t_cma();
        t_rlc();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule